// File: doc/BRIEF.md
# Paged Address Translator with Tagged Translation Buffer

This block turns a virtual address into a physical address for a processor that uses single-level paging. The virtual address is split into a page number and an offset inside the page. The page number first goes through a bounds check against a length register. It is then looked up in a small fully associative translation buffer, where every entry is compared at once. A buffer hit answers on the next cycle and does not touch memory.

On a miss, a walker reads one page-table entry from memory at the base register plus the page number. A valid entry is installed in the buffer and the translation completes. An entry whose valid bit is clear produces a fault instead. Each buffer entry carries an address-space tag, so translations from several processes can stay in the buffer together. An entry loaded from a table entry whose wired bit is set is pinned: refill never replaces it, and the flush-all input spares it.

Requests are accepted one at a time and answered in order. While a walk is in progress the request port stalls. Software-side state is loaded through a small register-write port that holds the table base, the table length and the current address-space tag.

Top module: `xlat_mmu`

## Requirements
- R1: After reset, resp_valid and mem_rd_en are low and req_ready is high. The base, length and current tag registers are all zero, so any request faults on bounds.
- R2: A successful response has resp_pa = {frame, offset}, with the offset bits copied unchanged from the request. The page size PAGE_BYTES is a power of two from 512 to 8192, and the offset is log2(PAGE_BYTES) bits wide.
- R3: A page number greater than or equal to the length register gives resp_fault = 1 (bounds) one cycle after acceptance. No memory read is made.
- R4: A buffer hit (same page number and same tag as the current tag register) responds one cycle after acceptance with resp_fault = 0 and makes no memory read.
- R5: A miss makes exactly one memory read, a one-cycle mem_rd_en pulse at address base + page number. The entry read has the frame in bits [PFN_W-1:0], the valid bit at bit PFN_W and the wired bit at bit PFN_W+1. The response follows the cycle in which mem_rd_valid is seen.
- R6: A table entry with the valid bit clear gives resp_fault = 2 (invalid), and nothing is installed: a repeat request for that page reads memory again.
- R7: A buffered translation under one tag does not hit for a request made under another tag.
- R8: Refill victims are chosen round-robin. A pointer that starts at entry 0 moves to the slot after each victim, and pinned slots are skipped.
- R9: A pinned entry is never replaced. When every entry is pinned, a miss still completes its translation but installs nothing.
- R10: flush_all invalidates every entry that is not pinned, in one cycle. A refill in the same cycle still installs its entry.
- R11: A flush_id_en pulse invalidates every entry whose tag equals flush_id, pinned ones included, and leaves other tags alone.
- R12: req_ready is low from the acceptance of a miss until its response, so at most one walk is outstanding and responses stay in request order.
- R13: A cfg_we write with cfg_sel 0 loads the table base, with 1 loads the table length, and with 2 loads the current tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_va | input | VPN_W+log2(PAGE_BYTES) | Virtual address |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_pa | output | PFN_W+log2(PAGE_BYTES) | Physical address (zero on fault) |
| resp_fault | output | 2 | 0 none, 1 bounds, 2 invalid entry |
| mem_rd_en | output | 1 | Page-table read strobe |
| mem_rd_addr | output | PTA_W | Page-table entry address |
| mem_rd_valid | input | 1 | Read data present |
| mem_rd_data | input | PFN_W+2 | Page-table entry |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | PTA_W | Register write value |
| flush_all | input | 1 | Drop all non-pinned entries |
| flush_id_en | input | 1 | Drop entries carrying flush_id |
| flush_id | input | ASID_W | Tag to drop |

## Verification
A buffer refill and a flush-all can land on the same clock edge. The bench provokes this by holding flush_all high in exactly the cycle in which the walker sees mem_rd_valid for a pending miss. It judges the outcome at the ports. The new page must hit afterwards with no memory read, while a page that had been buffered before the flush must take a fresh walk. The same run also checks that req_ready stays low while that walk is pending.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_BOUNDS  = 2'd1,
    FLT_INVALID = 2'd2
  } flt_e;

  localparam logic [1:0] CFG_BASE = 2'd0;
  localparam logic [1:0] CFG_LEN  = 2'd1;
  localparam logic [1:0] CFG_ASID = 2'd2;
endpackage

// File: rtl/xlat_regs.sv
module xlat_regs #(
  parameter int PTA_W  = 16,
  parameter int LEN_W  = 7,
  parameter int ASID_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [PTA_W-1:0]  cfg_wdata,
  output logic [PTA_W-1:0]  pt_base,
  output logic [LEN_W-1:0]  pt_len,
  output logic [ASID_W-1:0] cur_asid
);
  import xlat_pkg::*;

  // R13: register writes by select code
  always_ff @(posedge clk) begin
    if (rst) begin
      pt_base  <= '0;
      pt_len   <= '0;
      cur_asid <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        CFG_BASE: pt_base  <= cfg_wdata;
        CFG_LEN:  pt_len   <= cfg_wdata[LEN_W-1:0];
        CFG_ASID: cur_asid <= cfg_wdata[ASID_W-1:0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/xlat_cam.sv
module xlat_cam #(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 6,
  parameter int PFN_W   = 6,
  parameter int ASID_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  input  logic              refill_en,
  input  logic [VPN_W-1:0]  refill_vpn,
  input  logic [ASID_W-1:0] refill_asid,
  input  logic [PFN_W-1:0]  refill_pfn,
  input  logic              refill_wired,
  input  logic              flush_all,
  input  logic              flush_id_en,
  input  logic [ASID_W-1:0] flush_id
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld, wir, pin, match, wr_mask;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [IDX_W-1:0]   rr_q, vic;
  logic               vic_found;

  assign pin = vld & wir;

  // parallel compare across all entries
  always_comb begin
    lk_pfn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      match[i] = vld[i] && (vpn_q[i] == lk_vpn) && (asid_q[i] == lk_asid);
      if (match[i]) lk_pfn = lk_pfn | pfn_q[i];
    end
    lk_hit = |match;
  end

  // R8/R9: round-robin victim from the pointer, skipping pinned slots
  always_comb begin
    vic_found = 1'b0;
    vic       = rr_q;
    for (int k = 0; k < ENTRIES; k++) begin
      int j;
      j = (int'(rr_q) + k) % ENTRIES;
      if (!vic_found && !pin[j]) begin
        vic_found = 1'b1;
        vic       = IDX_W'(j);
      end
    end
    wr_mask = '0;
    if (refill_en && vic_found) wr_mask[vic] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= '0;
      wir  <= '0;
      rr_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (flush_all && !pin[i]) vld[i] <= 1'b0;
        if (flush_id_en && vld[i] && (asid_q[i] == flush_id)) begin
          vld[i] <= 1'b0;
          wir[i] <= 1'b0;
        end
        if (wr_mask[i]) begin  // R10: refill wins over a same-cycle flush
          vld[i] <= 1'b1;
          wir[i] <= refill_wired;
        end
      end
      if (refill_en && vic_found)
        rr_q <= (int'(vic) == ENTRIES - 1) ? '0 : vic + 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      always_ff @(posedge clk) begin
        if (wr_mask[g]) begin
          vpn_q[g]  <= refill_vpn;
          asid_q[g] <= refill_asid;
          pfn_q[g]  <= refill_pfn;
        end
      end
      // R9: a pinned entry keeps its contents unless a tag flush hits it
      p_pinned_kept_r9: assert property (@(posedge clk) disable iff (rst)
        pin[g] && !flush_id_en |=> vld[g] && vpn_q[g] == $past(vpn_q[g])
                                   && pfn_q[g] == $past(pfn_q[g]));
    end
  endgenerate

  // R7: page number plus tag selects at most one entry
  p_unique_match_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));

  // R10: after flush_all only formerly pinned or freshly written slots stay valid
  p_flush_all_r10: assert property (@(posedge clk) disable iff (rst)
    flush_all |=> (vld & ~$past(pin) & ~$past(wr_mask)) == '0);
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker #(
  parameter int VPN_W  = 6,
  parameter int PFN_W  = 6,
  parameter int OFF_W  = 10,
  parameter int ASID_W = 4,
  parameter int PTA_W  = 16,
  parameter int LEN_W  = VPN_W + 1,
  parameter int VA_W   = VPN_W + OFF_W,
  parameter int PA_W   = PFN_W + OFF_W,
  parameter int PTE_W  = PFN_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  output logic              resp_valid,
  output logic [PA_W-1:0]   resp_pa,
  output logic [1:0]        resp_fault,
  output logic [VPN_W-1:0]  lk_vpn,
  input  logic              lk_hit,
  input  logic [PFN_W-1:0]  lk_pfn,
  input  logic [PTA_W-1:0]  pt_base,
  input  logic [LEN_W-1:0]  pt_len,
  input  logic [ASID_W-1:0] cur_asid,
  output logic              mem_rd_en,
  output logic [PTA_W-1:0]  mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [PTE_W-1:0]  mem_rd_data,
  output logic              refill_en,
  output logic [VPN_W-1:0]  refill_vpn,
  output logic [ASID_W-1:0] refill_asid,
  output logic [PFN_W-1:0]  refill_pfn,
  output logic              refill_wired
);
  import xlat_pkg::*;

  typedef enum logic {ST_IDLE, ST_WAIT} st_e;
  st_e               st;
  logic [VA_W-1:0]   va_q;
  logic [ASID_W-1:0] asid_q;
  logic              accept, oob, pte_ok;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign lk_vpn    = req_va[VA_W-1:OFF_W];
  assign oob       = {1'b0, lk_vpn} >= {1'b0, pt_len};
  assign pte_ok    = mem_rd_data[PFN_W];

  assign refill_en    = (st == ST_WAIT) && mem_rd_valid && pte_ok;
  assign refill_vpn   = va_q[VA_W-1:OFF_W];
  assign refill_asid  = asid_q;
  assign refill_pfn   = mem_rd_data[PFN_W-1:0];
  assign refill_wired = mem_rd_data[PFN_W+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      va_q        <= '0;
      asid_q      <= '0;
      resp_valid  <= 1'b0;
      resp_pa     <= '0;
      resp_fault  <= FLT_NONE;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
    end else begin
      resp_valid <= 1'b0;
      mem_rd_en  <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          va_q   <= req_va;
          asid_q <= cur_asid;
          if (oob) begin
            resp_valid <= 1'b1;
            resp_pa    <= '0;
            resp_fault <= FLT_BOUNDS;
          end else if (lk_hit) begin
            resp_valid <= 1'b1;
            resp_pa    <= {lk_pfn, req_va[OFF_W-1:0]};
            resp_fault <= FLT_NONE;
          end else begin
            st          <= ST_WAIT;
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= pt_base + PTA_W'(lk_vpn);
          end
        end
        ST_WAIT: if (mem_rd_valid) begin
          st         <= ST_IDLE;
          resp_valid <= 1'b1;
          if (pte_ok) begin
            resp_pa    <= {mem_rd_data[PFN_W-1:0], va_q[OFF_W-1:0]};
            resp_fault <= FLT_NONE;
          end else begin
            resp_pa    <= '0;
            resp_fault <= FLT_INVALID;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_bounds_no_read_r3: assert property (@(posedge clk) disable iff (rst)
    accept && oob |=> resp_valid && resp_fault == FLT_BOUNDS && !mem_rd_en);

  p_hit_no_read_r4: assert property (@(posedge clk) disable iff (rst)
    accept && !oob && lk_hit |=> resp_valid && resp_fault == FLT_NONE && !mem_rd_en);

  p_single_read_r5: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  p_offset_kept_r2: assert property (@(posedge clk) disable iff (rst)
    resp_valid && resp_fault == FLT_NONE |-> resp_pa[OFF_W-1:0] == va_q[OFF_W-1:0]);

  p_stall_walk_r12: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> !req_ready);
endmodule

// File: rtl/xlat_mmu.sv
module xlat_mmu #(
  parameter int PAGE_BYTES = 1024,
  parameter int VPN_W      = 6,
  parameter int PFN_W      = 6,
  parameter int ASID_W     = 4,
  parameter int ENTRIES    = 4,
  parameter int PTA_W      = 16,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int VA_W      = VPN_W + OFF_W,
  localparam int PA_W      = PFN_W + OFF_W,
  localparam int PTE_W     = PFN_W + 2,
  localparam int LEN_W     = VPN_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  output logic              resp_valid,
  output logic [PA_W-1:0]   resp_pa,
  output logic [1:0]        resp_fault,
  output logic              mem_rd_en,
  output logic [PTA_W-1:0]  mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [PTE_W-1:0]  mem_rd_data,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [PTA_W-1:0]  cfg_wdata,
  input  logic              flush_all,
  input  logic              flush_id_en,
  input  logic [ASID_W-1:0] flush_id
);
  logic [PTA_W-1:0]  pt_base;
  logic [LEN_W-1:0]  pt_len;
  logic [ASID_W-1:0] cur_asid;
  logic [VPN_W-1:0]  lk_vpn, refill_vpn;
  logic [PFN_W-1:0]  lk_pfn, refill_pfn;
  logic [ASID_W-1:0] refill_asid;
  logic              lk_hit, refill_en, refill_wired;

  xlat_regs #(.PTA_W(PTA_W), .LEN_W(LEN_W), .ASID_W(ASID_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .pt_base(pt_base), .pt_len(pt_len), .cur_asid(cur_asid));

  xlat_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) u_cam (
    .clk(clk), .rst(rst), .lk_vpn(lk_vpn), .lk_asid(cur_asid),
    .lk_hit(lk_hit), .lk_pfn(lk_pfn),
    .refill_en(refill_en), .refill_vpn(refill_vpn), .refill_asid(refill_asid),
    .refill_pfn(refill_pfn), .refill_wired(refill_wired),
    .flush_all(flush_all), .flush_id_en(flush_id_en), .flush_id(flush_id));

  xlat_walker #(.VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W), .ASID_W(ASID_W),
                .PTA_W(PTA_W), .LEN_W(LEN_W)) u_walk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .resp_valid(resp_valid), .resp_pa(resp_pa), .resp_fault(resp_fault),
    .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_pfn(lk_pfn),
    .pt_base(pt_base), .pt_len(pt_len), .cur_asid(cur_asid),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .refill_en(refill_en), .refill_vpn(refill_vpn), .refill_asid(refill_asid),
    .refill_pfn(refill_pfn), .refill_wired(refill_wired));

  // R2: page size must be a power of two from 512 to 8192 bytes
  initial begin
    if (PAGE_BYTES < 512 || PAGE_BYTES > 8192 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0)
      $error("xlat_mmu: PAGE_BYTES out of range");
  end
endmodule

// File: tb/test_xlat_mmu.sv
`timescale 1ns/1ps
module test_xlat_mmu;
  logic        clk = 1'b0, rst = 1'b1;
  logic        req_valid = 1'b0, req_ready;
  logic [15:0] req_va = '0;
  logic        resp_valid;
  logic [15:0] resp_pa;
  logic [1:0]  resp_fault;
  logic        mem_rd_en, mem_rd_valid = 1'b0;
  logic [15:0] mem_rd_addr;
  logic [7:0]  mem_rd_data = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        flush_all = 1'b0, flush_id_en = 1'b0;
  logic [3:0]  flush_id = '0;

  int n_chk = 0, n_fail = 0, rd_cnt = 0;
  bit done = 0;
  logic [7:0] pt_mem [0:127];

  xlat_mmu i_xlat_mmu (.*);

  always #5 clk = ~clk;

  // page-table memory: one-cycle read latency, counts reads
  always @(posedge clk) begin
    mem_rd_valid <= 1'b0;
    if (mem_rd_en) begin
      mem_rd_valid <= 1'b1;
      mem_rd_data  <= pt_mem[mem_rd_addr[6:0]];
      rd_cnt       <= rd_cnt + 1;
    end
  end

  // entry: [7] wired, [6] valid, [5:0] frame
  function automatic logic [7:0] pte_of(int v);
    if (v == 5) return 8'h00;
    if (v >= 30 && v <= 33) return {2'b11, 6'(v + 1)};
    return {2'b01, 6'(v + 20)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(logic [1:0] sel, logic [15:0] val);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic pulse_flush_all();
    @(negedge clk); flush_all = 1'b1;
    @(negedge clk); flush_all = 1'b0;
  endtask

  task automatic pulse_flush_id(logic [3:0] id);
    @(negedge clk); flush_id_en = 1'b1; flush_id = id;
    @(negedge clk); flush_id_en = 1'b0;
  endtask

  task automatic xlat(string tag, logic [15:0] va, logic [15:0] epa, logic [1:0] eflt, int erd);
    int start, waited;
    @(negedge clk);
    start = rd_cnt; req_valid = 1'b1; req_va = va;
    @(posedge clk); #1 req_valid = 1'b0;
    waited = 0;
    while (!resp_valid && waited < 20) begin
      @(posedge clk); #1 waited++;
    end
    chk({tag, " resp_valid"}, 32'(resp_valid), 32'd1);
    chk({tag, " fault"}, 32'(resp_fault), 32'(eflt));
    chk({tag, " pa"}, 32'(resp_pa), 32'(epa));
    chk({tag, " reads"}, 32'(rd_cnt - start), 32'(erd));
  endtask

  // {req, va, pa, fault, reads}; asid 0, base 16, len 40
  localparam int NV = 9;
  localparam logic [41:0] VEC [NV] = '{
    {4'd5,  16'h0923, 16'h5923, 2'd0, 4'd1},  // R5 first miss, slot 0
    {4'd4,  16'h0BFF, 16'h5BFF, 2'd0, 4'd0},  // R4 hit, top offset
    {4'd2,  16'h0C00, 16'h5C00, 2'd0, 4'd1},  // R2 zero offset miss
    {4'd6,  16'h1410, 16'h0000, 2'd2, 4'd1},  // R6 invalid entry
    {4'd3,  16'hB400, 16'h0000, 2'd1, 4'd0},  // R3 far out of bounds
    {4'd3,  16'hA000, 16'h0000, 2'd1, 4'd0},  // R3 page equal to length
    {4'd3,  16'h9C01, 16'hEC01, 2'd0, 4'd1},  // R3 last legal page
    {4'd4,  16'h0EAA, 16'h5EAA, 2'd0, 4'd0},  // R4 hit
    {4'd6,  16'h1410, 16'h0000, 2'd2, 4'd1}   // R6 nothing installed
  };

  initial begin
    for (int i = 0; i < 128; i++) pt_mem[i] = 8'h00;
    for (int v = 0; v < 40; v++) pt_mem[16 + v] = pte_of(v);

    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 resp_valid", 32'(resp_valid), 0);
    chk("R1 mem_rd_en", 32'(mem_rd_en), 0);
    chk("R1 req_ready", 32'(req_ready), 1);
    @(negedge clk); rst = 1'b0;
    xlat("R1 zero length", 16'h0000, 16'h0000, 2'd1, 0);

    cfg(2'd0, 16'd16);  // R13 base
    cfg(2'd1, 16'd40);  // R13 length
    cfg(2'd2, 16'd0);   // R13 tag

    for (int i = 0; i < NV; i++)
      xlat($sformatf("R%0d vec%0d", VEC[i][41:38], i),
           VEC[i][37:22], VEC[i][21:6], VEC[i][5:4], int'(VEC[i][3:0]));

    // R8 round-robin: slots 0..2 hold pages 2,3,39; pointer at 3
    xlat("R8 fill slot3", 16'h1C00, 16'h6C00, 2'd0, 1);
    xlat("R8 evict page2", 16'h2000, 16'h7000, 2'd0, 1);
    xlat("R8 page2 refetch", 16'h0800, 16'h5800, 2'd0, 1);
    xlat("R8 page39 kept", 16'h9C00, 16'hEC00, 2'd0, 0);

    // R7 tag match
    cfg(2'd2, 16'd1);
    xlat("R7 other tag miss", 16'h1C00, 16'h6C00, 2'd0, 1);
    cfg(2'd2, 16'd0);
    xlat("R7 own tag hit", 16'h1C00, 16'h6C00, 2'd0, 0);
    cfg(2'd2, 16'd1);
    xlat("R7 tag1 hit", 16'h1C00, 16'h6C00, 2'd0, 0);

    // R11 tag flush
    pulse_flush_id(4'd1);
    cfg(2'd2, 16'd0);
    xlat("R11 other tag kept a", 16'h2000, 16'h7000, 2'd0, 0);
    xlat("R11 other tag kept b", 16'h0800, 16'h5800, 2'd0, 0);
    cfg(2'd2, 16'd1);
    xlat("R11 flushed tag miss", 16'h1C00, 16'h6C00, 2'd0, 1);
    cfg(2'd2, 16'd0);

    // R10 + R12: flush_all in the refill cycle of page 10
    begin
      int start, waited;
      @(negedge clk);
      start = rd_cnt; req_valid = 1'b1; req_va = 16'h2800;
      @(posedge clk); #1 req_valid = 1'b0;
      chk("R12 stall during walk", 32'(req_ready), 0);
      waited = 0;
      while (!mem_rd_valid && waited < 20) begin
        @(posedge clk); #1 waited++;
      end
      flush_all = 1'b1;
      @(posedge clk); #1 flush_all = 1'b0;
      chk("R10 concurrent resp", 32'(resp_valid), 1);
      chk("R10 concurrent pa", 32'(resp_pa), 32'h7800);
      chk("R10 concurrent reads", 32'(rd_cnt - start), 1);
    end
    xlat("R10 refill survived", 16'h2800, 16'h7800, 2'd0, 0);
    xlat("R10 old entry flushed", 16'h0800, 16'h5800, 2'd0, 1);

    // R9 pinned entries fill all four slots
    xlat("R9 pin30", 16'h7800, 16'h7C00, 2'd0, 1);
    xlat("R9 pin31", 16'h7C00, 16'h8000, 2'd0, 1);
    xlat("R9 pin32", 16'h8000, 16'h8400, 2'd0, 1);
    xlat("R9 pin33", 16'h8400, 16'h8800, 2'd0, 1);
    pulse_flush_all();
    xlat("R9 pinned survive flush", 16'h7800, 16'h7C00, 2'd0, 0);
    xlat("R9 all pinned miss", 16'h2C00, 16'h7C00, 2'd0, 1);
    xlat("R9 no install", 16'h2C00, 16'h7C00, 2'd0, 1);
    xlat("R9 pin33 kept", 16'h8400, 16'h8800, 2'd0, 0);

    pulse_flush_id(4'd0);
    xlat("R11 pinned dropped by tag", 16'h7C00, 16'h8000, 2'd0, 1);

    // R13 base and length writes take effect
    cfg(2'd0, 16'd17);  // page 1 now reads the entry stored for page 2
    xlat("R13 new base", 16'h0400, 16'h5800, 2'd0, 1);
    cfg(2'd1, 16'd2);
    xlat("R13 new length", 16'h0800, 16'h0000, 2'd1, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule